// File: doc/BRIEF.md
# Serial DAC Update Transmitter

This block sends a single update word to a four-channel, 12-bit serial DAC over a write-only SPI link. A client presents a 4-bit command code, a 4-bit channel address and a 12-bit sample, then pulses `start`. The block latches these inputs into a frame and shifts the frame out on `mosi`, most significant bit first. It generates the serial clock by dividing the system clock and frames each transfer with an active-low chip select. The DAC takes the word when chip select rises.

A parameter picks the frame length. The short form has 24 bits. The long form has 32 bits: eight zero bits come first, then the same 24 bits. All don't-care and pad positions are driven as zero. After a synchronous reset, the block holds the DAC's active-low clear line low for one serial-clock period, then keeps it high. Typical codes are command `0011` (write the input register and update the output) and address `1111` (all channels at once). The block passes any 4-bit code through without decoding it.

Top module: `dacSpiTx`

## Requirements
- R1: With WIDE_FRAME=0, the transfer carries 24 bits, MSB first. Bits [23:20] hold the command, bits [19:16] the address, bits [15:4] the sample, and bits [3:0] are 0.
- R2: With WIDE_FRAME=1, the transfer carries 32 bits. The top 8 bits are 0 and the lower 24 bits follow the R1 layout.
- R3: `sck` idles low whenever `csN` is high. During a transfer, consecutive rising edges of `sck` are exactly SCK_DIV system-clock cycles apart.
- R4: While `csN` stays low, `mosi` changes only in the cycle where `sck` falls. The DAC can therefore sample it on the rising edge.
- R5: `csN` falls exactly SCK_DIV cycles before the first rising edge of `sck`. It rises exactly 2*SCK_DIV cycles after the last rising edge, which is one full period after the last bit period ends.
- R6: `busy` is high for the whole time `csN` is low. A `start` pulse seen while `busy` is high produces no extra transfer.
- R7: The command, address and sample are captured in the cycle `start` is accepted. Changing them later has no effect on the frame being sent.
- R8: `done` is a one-cycle pulse in the same cycle that `csN` returns high, and `busy` is low in that cycle.
- R9: `clrN` is low while `rst` is high and for SCK_DIV cycles after `rst` falls. After that it stays high. `busy` is high during that window and a `start` pulse in it is ignored.
- R10: While `rst` is high, `csN`=1, `sck`=0, `mosi`=0 and `done`=0.
- R11: A `start` given in the cycle `done` is high is accepted at once, so `csN` is low again one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Request one transfer (accepted only when not busy) |
| cmd | input | 4 | Command code placed in the frame |
| addr | input | 4 | Channel address placed in the frame |
| sample | input | 12 | Data word placed in the frame |
| busy | output | 1 | Transfer or post-reset clear in progress |
| done | output | 1 | One-cycle pulse at the end of a transfer |
| sck | output | 1 | Serial clock to the DAC |
| mosi | output | 1 | Serial data to the DAC |
| csN | output | 1 | Chip select, active low |
| clrN | output | 1 | DAC clear, active low |

## Verification
The hardest situations to reach from the ports are the ones where `start` arrives while the block cannot accept it. The first is during the clear window right after reset. The second is partway through a frame while the payload inputs are also changing. The stimulus releases reset and pulses `start` in the same cycle. It then fires a second `start` with a different payload in the middle of a transfer, and it issues a new `start` in the exact cycle `done` is seen. A serial-side watcher rebuilds each word from the `sck` edges, so any unwanted or corrupted frame shows up as a scoreboard mismatch or as an unexpected word.

// File: rtl/dacSpiPkg.sv
package dacSpiPkg;

  typedef enum logic [2:0] {
    ST_CLEAR,
    ST_IDLE,
    ST_LEAD,
    ST_SHIFT,
    ST_TAIL
  } dacState_t;

  // Strobes issued by the control and acted on by the datapath
  typedef struct packed {
    logic load;     // capture a new frame
    logic shift;    // advance the serial register by one bit
    logic sckRise;  // drive the serial clock high
    logic sckFall;  // drive the serial clock low
    logic csOn;     // pull chip select low
    logic csOff;    // release chip select
    logic clrOff;   // release the DAC clear line
  } dacStrobe_t;

endpackage

// File: rtl/dacSpiCtrl.sv
module dacSpiCtrl
  import dacSpiPkg::*;
#(
  parameter int SCK_DIV    = 4,
  parameter int FRAME_BITS = 24
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       start,
  output dacStrobe_t strobe,
  output logic       busy,
  output logic       done
);

  localparam int HALF = SCK_DIV / 2;
  localparam int PW   = (SCK_DIV > 2) ? $clog2(SCK_DIV) : 1;
  localparam int BW   = $clog2(FRAME_BITS);

  dacState_t state;
  logic [PW-1:0] phase;
  logic [BW-1:0] bitCnt;
  logic lastPhase;
  logic lastBit;

  assign lastPhase = (phase == PW'(SCK_DIV - 1));
  assign lastBit   = (bitCnt == BW'(FRAME_BITS - 1));
  assign busy      = (state != ST_IDLE);

  always_comb begin
    strobe = '0;
    unique case (state)
      ST_IDLE: begin
        strobe.load = start;
        strobe.csOn = start;
      end
      ST_LEAD:  strobe.sckRise = lastPhase;
      ST_SHIFT: begin
        strobe.sckFall = (phase == PW'(HALF - 1));
        strobe.shift   = (phase == PW'(HALF - 1));
        strobe.sckRise = lastPhase && !lastBit;
      end
      ST_TAIL:  strobe.csOff  = lastPhase;
      ST_CLEAR: strobe.clrOff = lastPhase;
      default:  strobe = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= ST_CLEAR;
      phase  <= '0;
      bitCnt <= '0;
      done   <= 1'b0;
    end else begin
      done <= 1'b0;
      if (state == ST_IDLE) begin
        phase <= '0;
        if (start) begin
          state <= ST_LEAD;
        end
      end else begin
        phase <= lastPhase ? '0 : phase + 1'b1;
        if (lastPhase) begin
          unique case (state)
            ST_LEAD: begin
              state  <= ST_SHIFT;
              bitCnt <= '0;
            end
            ST_SHIFT: begin
              if (lastBit) state <= ST_TAIL;
              else         bitCnt <= bitCnt + 1'b1;
            end
            ST_TAIL: begin
              state <= ST_IDLE;
              done  <= 1'b1;
            end
            ST_CLEAR: state <= ST_IDLE;
            default:  state <= ST_IDLE;
          endcase
        end
      end
    end
  end

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R8

  AST_NO_LOAD_BUSY: assert property (@(posedge clk) disable iff (rst)
    (busy && start) |=> (state != ST_LEAD || $past(state) == ST_LEAD)); // R6

endmodule

// File: rtl/dacSpiData.sv
module dacSpiData
  import dacSpiPkg::*;
#(
  parameter bit WIDE_FRAME = 1'b0,
  parameter int FRAME_BITS = 24
) (
  input  logic        clk,
  input  logic        rst,
  input  dacStrobe_t  strobe,
  input  logic [3:0]  cmd,
  input  logic [3:0]  addr,
  input  logic [11:0] sample,
  output logic        sck,
  output logic        mosi,
  output logic        csN,
  output logic        clrN
);

  logic [FRAME_BITS-1:0] frameWord;
  logic [FRAME_BITS-1:0] shiftReg;

  generate
    if (WIDE_FRAME) begin : gWide
      assign frameWord = {8'h00, cmd, addr, sample, 4'h0};
    end else begin : gShort
      assign frameWord = {cmd, addr, sample, 4'h0};
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      shiftReg <= '0;
      sck      <= 1'b0;
      csN      <= 1'b1;
      clrN     <= 1'b0;
    end else begin
      if (strobe.load)       shiftReg <= frameWord;
      else if (strobe.shift) shiftReg <= {shiftReg[FRAME_BITS-2:0], 1'b0};
      if (strobe.sckRise)      sck <= 1'b1;
      else if (strobe.sckFall) sck <= 1'b0;
      if (strobe.csOn)       csN <= 1'b0;
      else if (strobe.csOff) csN <= 1'b1;
      if (strobe.clrOff) clrN <= 1'b1;
    end
  end

  assign mosi = shiftReg[FRAME_BITS-1];

  AST_SCK_IDLE_LOW: assert property (@(posedge clk) disable iff (rst)
    csN |-> !sck); // R3

  AST_MOSI_AT_FALL: assert property (@(posedge clk) disable iff (rst)
    (!csN && $past(!csN) && (mosi != $past(mosi))) |-> $fell(sck)); // R4

  AST_CLR_HOLD: assert property (@(posedge clk) disable iff (rst)
    clrN |=> clrN); // R9

endmodule

// File: rtl/dacSpiTx.sv
module dacSpiTx
  import dacSpiPkg::*;
#(
  parameter int SCK_DIV    = 4,
  parameter bit WIDE_FRAME = 1'b0
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        start,
  input  logic [3:0]  cmd,
  input  logic [3:0]  addr,
  input  logic [11:0] sample,
  output logic        busy,
  output logic        done,
  output logic        sck,
  output logic        mosi,
  output logic        csN,
  output logic        clrN
);

  localparam int FRAME_BITS = WIDE_FRAME ? 32 : 24;

  dacStrobe_t strobe;

  dacSpiCtrl #(
    .SCK_DIV   (SCK_DIV),
    .FRAME_BITS(FRAME_BITS)
  ) ctrl (
    .clk   (clk),
    .rst   (rst),
    .start (start),
    .strobe(strobe),
    .busy  (busy),
    .done  (done)
  );

  dacSpiData #(
    .WIDE_FRAME(WIDE_FRAME),
    .FRAME_BITS(FRAME_BITS)
  ) data (
    .clk   (clk),
    .rst   (rst),
    .strobe(strobe),
    .cmd   (cmd),
    .addr  (addr),
    .sample(sample),
    .sck   (sck),
    .mosi  (mosi),
    .csN   (csN),
    .clrN  (clrN)
  );

  AST_DONE_CS_RISE: assert property (@(posedge clk) disable iff (rst)
    done |-> ($rose(csN) && !busy)); // R8

  AST_CS_BUSY: assert property (@(posedge clk) disable iff (rst)
    !csN |-> busy); // R6

endmodule

// File: tb/dacSpiTx_test.sv
module spiWatch #(
  parameter int PERIOD = 4
) (
  input  logic        clk,
  input  logic        sck,
  input  logic        mosi,
  input  logic        csN,
  output logic        wordValid,
  output logic [31:0] word,
  output int          nBits,
  output int          leadCyc,
  output int          tailCyc,
  output int          badEdge,
  output int          badPeriod,
  output int          idleSck
);
  logic prevSck = 1'b0;
  logic prevCs = 1'b1;
  logic prevMosi = 1'b0;
  logic [31:0] acc = '0;
  int cyc = 0;
  int tFall = 0;
  int lastRise = 0;
  int n = 0;

  initial begin
    wordValid = 0; word = 0; nBits = 0; leadCyc = 0; tailCyc = 0;
    badEdge = 0; badPeriod = 0; idleSck = 0;
  end

  always @(negedge clk) begin
    cyc++;
    wordValid = 1'b0;
    if (prevCs && !csN) begin
      tFall = cyc; n = 0; acc = '0;
    end
    if (!csN && sck && !prevSck) begin
      acc = {acc[30:0], mosi};
      if (n == 0) leadCyc = cyc - tFall;
      else if (cyc - lastRise != PERIOD) badPeriod++;
      lastRise = cyc;
      n++;
    end
    if (!prevCs && csN) begin
      word = acc; nBits = n; tailCyc = cyc - lastRise; wordValid = 1'b1;
    end
    if (csN && sck) idleSck++;
    if (!csN && !prevCs && (mosi != prevMosi) && !(prevSck && !sck)) badEdge++;
    prevSck = sck; prevCs = csN; prevMosi = mosi;
  end
endmodule

module dacSpiTx_test;
  localparam int DIV_A = 4;
  localparam int DIV_B = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic startA = 1'b0, startB = 1'b0;
  logic [3:0] cmd = '0, addr = '0;
  logic [11:0] sample = '0;
  logic busyA, doneA, sckA, mosiA, csNA, clrNA;
  logic busyB, doneB, sckB, mosiB, csNB, clrNB;

  int checks = 0;
  int errors = 0;
  int wordsA = 0;
  bit finished = 0;
  logic [31:0] expA[$];
  logic [31:0] expB[$];

  always #4 clk = ~clk;

  dacSpiTx #(.SCK_DIV(DIV_A), .WIDE_FRAME(1'b0)) uut (
    .clk(clk), .rst(rst), .start(startA), .cmd(cmd), .addr(addr), .sample(sample),
    .busy(busyA), .done(doneA), .sck(sckA), .mosi(mosiA), .csN(csNA), .clrN(clrNA));

  dacSpiTx #(.SCK_DIV(DIV_B), .WIDE_FRAME(1'b1)) uutWide (
    .clk(clk), .rst(rst), .start(startB), .cmd(cmd), .addr(addr), .sample(sample),
    .busy(busyB), .done(doneB), .sck(sckB), .mosi(mosiB), .csN(csNB), .clrN(clrNB));

  logic vA, vB;
  logic [31:0] wA, wB;
  int nA, nB, leadA, leadB, tailA, tailB, beA, beB, bpA, bpB, isA, isB;

  spiWatch #(.PERIOD(DIV_A)) watchA (.clk(clk), .sck(sckA), .mosi(mosiA), .csN(csNA),
    .wordValid(vA), .word(wA), .nBits(nA), .leadCyc(leadA), .tailCyc(tailA),
    .badEdge(beA), .badPeriod(bpA), .idleSck(isA));
  spiWatch #(.PERIOD(DIV_B)) watchB (.clk(clk), .sck(sckB), .mosi(mosiB), .csN(csNB),
    .wordValid(vB), .word(wB), .nBits(nB), .leadCyc(leadB), .tailCyc(tailB),
    .badEdge(beB), .badPeriod(bpB), .idleSck(isB));

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Scoreboard monitor: compares each reconstructed word with the queue head
  always @(posedge clk) begin
    if (vA) begin
      wordsA++;
      if (expA.size() == 0) check(1'b0, "R6/R9 unexpected frame", wA, 0);
      else begin
        logic [31:0] e;
        e = expA.pop_front();
        check(wA == e, "R1 frame content", wA, e);
        check(nA == 24, "R1 frame length", nA, 24);
        check(leadA == DIV_A, "R5 lead time", leadA, DIV_A);
        check(tailA == 2 * DIV_A, "R5 tail time", tailA, 2 * DIV_A);
      end
    end
    if (vB) begin
      if (expB.size() == 0) check(1'b0, "R2 unexpected frame", wB, 0);
      else begin
        logic [31:0] e;
        e = expB.pop_front();
        check(wB == e, "R2 frame content", wB, e);
        check(nB == 32, "R2 frame length", nB, 32);
        check(leadB == DIV_B, "R5 lead time wide", leadB, DIV_B);
        check(tailB == 2 * DIV_B, "R5 tail time wide", tailB, 2 * DIV_B);
      end
    end
  end

  task automatic sendA(input logic [3:0] c, input logic [3:0] a, input logic [11:0] s);
    @(negedge clk);
    while (busyA) @(negedge clk);
    cmd = c; addr = a; sample = s;
    expA.push_back({8'h00, c, a, s, 4'h0});
    startA = 1'b1;
    @(negedge clk);
    startA = 1'b0;
  endtask

  task automatic sendB(input logic [3:0] c, input logic [3:0] a, input logic [11:0] s);
    @(negedge clk);
    while (busyB) @(negedge clk);
    cmd = c; addr = a; sample = s;
    expB.push_back({8'h00, c, a, s, 4'h0});
    startB = 1'b1;
    @(negedge clk);
    startB = 1'b0;
  endtask

  task automatic waitDoneA;
    do @(negedge clk); while (!doneA);
    check(csNA == 1'b1, "R8 csN high with done", csNA, 1);
    check(busyA == 1'b0, "R8 busy low with done", busyA, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    // R10 reset state
    check(csNA == 1'b1, "R10 csN in reset", csNA, 1);
    check(sckA == 1'b0, "R10 sck in reset", sckA, 0);
    check(mosiA == 1'b0, "R10 mosi in reset", mosiA, 0);
    check(doneA == 1'b0, "R10 done in reset", doneA, 0);
    check(clrNA == 1'b0, "R9 clrN low in reset", clrNA, 0);
    check(busyA == 1'b1, "R9 busy in reset", busyA, 1);

    // R9 release reset and try a start during the clear window
    rst = 1'b0;
    startA = 1'b1;
    @(negedge clk);
    startA = 1'b0;
    for (int k = 2; k < DIV_A; k++) @(negedge clk);
    check(clrNA == 1'b0, "R9 clrN still low", clrNA, 0);
    check(busyA == 1'b1, "R9 busy during clear", busyA, 1);
    @(negedge clk);
    check(clrNA == 1'b1, "R9 clrN released", clrNA, 1);
    check(busyA == 1'b0, "R9 idle after clear", busyA, 0);
    repeat (3) @(negedge clk);
    check(csNA == 1'b1, "R9 start in clear ignored", csNA, 1);

    // R1 typical all-channel update
    sendA(4'h3, 4'hF, 12'hABC);
    waitDoneA();
    @(negedge clk);
    check(doneA == 1'b0, "R8 done one cycle", doneA, 0);

    // R1 other patterns
    sendA(4'h0, 4'h1, 12'h000);
    waitDoneA();
    sendA(4'hA, 4'h5, 12'hFFF);
    waitDoneA();

    // R6/R7 start and payload changes while busy
    sendA(4'h3, 4'h2, 12'h5A5);
    repeat (6) @(negedge clk);
    cmd = 4'hC; addr = 4'h9; sample = 12'h123;
    startA = 1'b1;
    @(negedge clk);
    startA = 1'b0;
    check(busyA == 1'b1, "R6 busy during frame", busyA, 1);
    repeat (5) @(negedge clk);
    cmd = 4'h7; sample = 12'hFE0;
    waitDoneA();
    repeat (2 * DIV_A) @(negedge clk);
    check(csNA == 1'b1, "R6 no extra frame", csNA, 1);
    check(wordsA == 4, "R6 word count", wordsA, 4);

    // R11 back-to-back start in the done cycle
    sendA(4'h3, 4'hF, 12'h801);
    waitDoneA();
    cmd = 4'h1; addr = 4'h3; sample = 12'h7FE;
    expA.push_back({8'h00, 4'h1, 4'h3, 12'h7FE, 4'h0});
    startA = 1'b1;
    @(negedge clk);
    startA = 1'b0;
    check(csNA == 1'b0, "R11 immediate restart", csNA, 0);
    waitDoneA();

    // R2 wide frame
    sendB(4'h3, 4'hF, 12'h5A5);
    do @(negedge clk); while (!doneB);
    sendB(4'hE, 4'h0, 12'h00F);
    do @(negedge clk); while (!doneB);
    repeat (4) @(negedge clk);

    // R3/R4 accumulated serial timing checks
    check(bpA == 0 && bpB == 0, "R3 sck period", bpA + bpB, 0);
    check(isA == 0 && isB == 0, "R3 sck idle low", isA + isB, 0);
    check(beA == 0 && beB == 0, "R4 mosi changes at fall", beA + beB, 0);
    check(expA.size() == 0, "R1 all frames seen", expA.size(), 0);
    check(expB.size() == 0, "R2 all frames seen", expB.size(), 0);
    check(mosiA == 1'b0, "R10 mosi idle", mosiA, 0);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule